// File: doc/BRIEF.md
# Byte Serial Shift Engine with Selectable Clock Mode

This block moves one byte at a time over a four-wire synchronous serial link. A controller programs it through three small registers: control, status and data. In master mode, writing the data register starts a transfer. The block then derives the serial clock from the system clock through a prescaler with eight rate codes. It drives each data bit out on the master-out line and captures the master-in line on the sampling edges. After the eighth bit it raises a completion flag.

In slave mode the serial clock and the master-out line come from outside. Both are passed through synchronizers into the system clock domain. The block shifts its loaded byte onto the master-in line as the external clock runs.

While the block is a master, a low level on the select input is a fault. The block drops out of master mode, stops any transfer in progress, and raises both the fault and completion flags.

Top module: `spi_xfer_core`

## Requirements
- R1: After reset the control, status and data registers all read 0 and `sck_o` is low. The control register is at address 0, the status register at address 1 and the data register at address 2.
- R2: The clock polarity bit is control bit 1. Whenever no master transfer is running, `sck_o` sits at that bit's value. A control write that changes the bit changes `sck_o` in the next cycle.
- R3: A master transfer produces exactly 16 `sck_o` transitions and shifts the byte out most significant bit first. At the end it loads the captured `miso_i` byte into the data register. Master mode is control bit 0.
- R4: The phase is control bit 2. With phase 0, `mosi_o` carries the byte's top bit from the cycle after the data write, before the first clock edge. Bits are sampled on leading edges and changed on trailing edges. With phase 1, bits are changed on leading edges and sampled on trailing edges.
- R5: The rate code is control bits 5:3, read as {double, r1, r0}. The system clock divisor is 000→4, 001→16, 010→64, 011→128, 100→2, 101→8, 110→32 and 111→64. A master transfer therefore completes 8×divisor cycles after the write of the data register.
- R6: Status bit 0 is the completion flag. It sets when a transfer ends. A read of the status register followed by a read of the data register clears it. A data read without a prior status read leaves it set.
- R7: If the synchronized `ss_n_i` is low while master mode is set, the block does the following. It clears control bit 0 and aborts the transfer, returning `sck_o` to idle. It sets status bit 1 (fault) and status bit 0. The flags clear by the same status-then-data read sequence. No further master transfer starts until control bit 0 is written to 1 again.
- R8: In slave mode with `ss_n_i` low, the block synchronizes `sck_i` and `mosi_i`. It samples `mosi_i` on the edges chosen by the phase bit and shifts the loaded byte onto `miso_o`, most significant bit first. It sets the completion flag after the eighth sampling edge. `sck_o` does not toggle, and the rate code has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives the flag-clear sequence) |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register |
| sck_i | input | 1 | Serial clock in (slave mode) |
| sck_o | output | 1 | Serial clock out (master mode) |
| mosi_i | input | 1 | Master-out data in (slave mode) |
| mosi_o | output | 1 | Master-out data driven in master mode |
| miso_i | input | 1 | Master-in data captured in master mode |
| miso_o | output | 1 | Master-in data driven in slave mode |
| ss_n_i | input | 1 | Select input, active low |

## Verification
The bench builds the block with its defaults: byte width 8, two synchronizer stages and a two-bit address. With byte width 8, even the slowest rate code finishes in 1024 cycles. That lets all eight rate codes be walked, each under a different polarity and phase pairing, in looped-back master transfers. The two-stage synchronizer fixes the slave-mode latency at a few cycles. The slave tests therefore hold each external clock level for eight system cycles and check the captured byte and the shifted-out byte under two rate codes.

// File: rtl/spi_xfer_pkg.sv
// Package: shared control-register layout, register addresses and the
// rate-code to half-period mapping used by the prescaler.
// Assumes the control field sits in the low bits of the bus word.
package spi_xfer_pkg;

    // Control register layout; bit 0 is master, bit 5:3 the rate code.
    typedef struct packed {
        logic [2:0] rate;
        logic       cpha;
        logic       cpol;
        logic       master;
    } ctl_t;

    localparam int CTL_W  = $bits(ctl_t);
    localparam int HALF_W = 7;

    localparam int ADDR_CTL  = 0;
    localparam int ADDR_STAT = 1;
    localparam int ADDR_DATA = 2;

    // System clocks per half serial-clock period for each rate code.
    function automatic logic [HALF_W-1:0] half_period(input logic [2:0] code);
        logic [HALF_W-1:0] h;
        case (code)
            3'b000:  h = 7'd2;
            3'b001:  h = 7'd8;
            3'b010:  h = 7'd32;
            3'b011:  h = 7'd64;
            3'b100:  h = 7'd1;
            3'b101:  h = 7'd4;
            3'b110:  h = 7'd16;
            default: h = 7'd32;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/spi_rate_gen.sv
// Prescaler: while run is high, pulses tick once every half serial-clock
// period, as chosen by the rate code. Assumes run rises in the cycle after
// a transfer starts; the first tick then lands one half period later.
module spi_rate_gen
    import spi_xfer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] rate,
    output logic       tick
);

    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] half;

    assign half = half_period(rate);
    assign tick = run && (cnt_q == half - 1'b1);

    // Count system clocks within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/spi_bit_sync.sv
// Synchronizer: a chain of STAGES flops that brings one asynchronous bit
// into the system clock domain. Assumes the input is slower than the clock.
module spi_bit_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            // Capture the input in a single flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= RST_VAL;
                else        chain_q <= d;
            end
        end else begin : g_many
            // Shift the input through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/spi_shift_core.sv
// Shifter: holds the outgoing byte and assembles the incoming one. A load
// with phase 0 puts the top bit out at once; with phase 1 the first setup
// event does it. Setup events shift out, sample events shift in.
// Assumes load never coincides with a running transfer.
module spi_shift_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         cpha,
    input  logic         sample_ev,
    input  logic         setup_ev,
    input  logic         in_bit,
    output logic         out_bit,
    output logic [W-1:0] rx_now
);

    logic [W-1:0] tx_q;
    logic [W-1:0] rx_q;
    logic         out_q;

    // Outgoing path: load the byte, then present one bit per setup event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q  <= '0;
            out_q <= 1'b0;
        end else if (load) begin
            if (!cpha) begin
                out_q <= load_data[W-1];
                tx_q  <= {load_data[W-2:0], 1'b0};
            end else begin
                tx_q  <= load_data;
            end
        end else if (setup_ev) begin
            out_q <= tx_q[W-1];
            tx_q  <= {tx_q[W-2:0], 1'b0};
        end
    end

    // Incoming path: append the sampled bit at the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_q <= '0;
        else if (sample_ev) rx_q <= {rx_q[W-2:0], in_bit};
    end

    assign rx_now  = sample_ev ? {rx_q[W-2:0], in_bit} : rx_q;
    assign out_bit = out_q;

endmodule

// File: rtl/spi_xfer_core.sv
// Top: register access, the master edge sequencer, slave edge detection and
// the flag and fault logic around one shifter. Assumes slave sck_i runs no
// faster than clk/4 and the bus issues one access per cycle.
module spi_xfer_core
    import spi_xfer_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sck_i,
    output logic              sck_o,
    input  logic              mosi_i,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic              miso_o,
    input  logic              ss_n_i
);

    localparam int EDGE_W = $clog2(2 * DATA_W);
    localparam int CNT_W  = $clog2(DATA_W);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * DATA_W - 1);
    localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(DATA_W - 1);

    ctl_t              ctl_q;
    logic              done_q, fault_q, seen_q, busy_q, sck_q, sck_prev_q;
    logic [DATA_W-1:0] data_q;
    logic [EDGE_W-1:0] edge_cnt_q;
    logic [CNT_W-1:0]  samp_cnt_q;

    logic ss_s, sck_s, mosi_s, tick;
    logic wr_ctl, wr_data, rd_stat, rd_data, clr_flags;
    logic fault_ev, start, load_sh, m_end, s_end, set_done;
    logic slv_act, s_edge, s_lead, s_sample, s_setup, m_lead;
    logic sample_ev, setup_ev, in_bit, out_bit;
    logic [DATA_W-1:0] rx_now;

    spi_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ss_sync (
        .clk(clk), .rst_n(rst_n), .d(ss_n_i), .q(ss_s));
    spi_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
        .clk(clk), .rst_n(rst_n), .d(sck_i), .q(sck_s));
    spi_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_mosi_sync (
        .clk(clk), .rst_n(rst_n), .d(mosi_i), .q(mosi_s));

    spi_rate_gen u_rate (
        .clk(clk), .rst_n(rst_n), .run(busy_q), .rate(ctl_q.rate), .tick(tick));

    spi_shift_core #(.W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load_sh), .load_data(bus_wdata),
        .cpha(ctl_q.cpha), .sample_ev(sample_ev), .setup_ev(setup_ev),
        .in_bit(in_bit), .out_bit(out_bit), .rx_now(rx_now));

    // Bus decode.
    assign wr_ctl    = bus_wr && (int'(bus_addr) == ADDR_CTL);
    assign wr_data   = bus_wr && (int'(bus_addr) == ADDR_DATA);
    assign rd_stat   = bus_rd && (int'(bus_addr) == ADDR_STAT);
    assign rd_data   = bus_rd && (int'(bus_addr) == ADDR_DATA);
    assign clr_flags = rd_data && seen_q;

    // Master events.
    assign fault_ev = ctl_q.master && !ss_s;
    assign start    = wr_data && ctl_q.master && !busy_q && !fault_ev;
    assign load_sh  = wr_data && !busy_q;
    assign m_lead   = (edge_cnt_q[0] == 1'b0);
    assign m_end    = tick && (edge_cnt_q == LAST_EDGE);

    // Slave events from the synchronized clock.
    assign slv_act  = !ctl_q.master && !ss_s;
    assign s_edge   = slv_act && (sck_s != sck_prev_q);
    assign s_lead   = (sck_s != ctl_q.cpol);
    assign s_sample = s_edge && (s_lead ^ ctl_q.cpha);
    assign s_setup  = s_edge && !(s_lead ^ ctl_q.cpha);
    assign s_end    = s_sample && (samp_cnt_q == LAST_BIT);

    assign sample_ev = ctl_q.master ? (tick && (m_lead ^ ctl_q.cpha))  : s_sample;
    assign setup_ev  = ctl_q.master ? (tick && !(m_lead ^ ctl_q.cpha)) : s_setup;
    assign in_bit    = ctl_q.master ? miso_i : mosi_s;
    assign set_done  = (ctl_q.master && m_end) || s_end;

    // Control register; a fault clears master mode over any write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            if (wr_ctl)   ctl_q        <= ctl_t'(bus_wdata[CTL_W-1:0]);
            if (fault_ev) ctl_q.master <= 1'b0;
        end
    end

    // Master sequencer: busy window, serial clock level and edge count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            sck_q      <= 1'b0;
            edge_cnt_q <= '0;
        end else if (fault_ev) begin
            busy_q     <= 1'b0;
            edge_cnt_q <= '0;
        end else if (start) begin
            busy_q     <= 1'b1;
            sck_q      <= ctl_q.cpol;
            edge_cnt_q <= '0;
        end else if (tick) begin
            sck_q      <= ~sck_q;
            edge_cnt_q <= edge_cnt_q + 1'b1;
            if (edge_cnt_q == LAST_EDGE) busy_q <= 1'b0;
        end
    end

    // Slave edge history and sample counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_prev_q <= 1'b0;
            samp_cnt_q <= '0;
        end else begin
            sck_prev_q <= sck_s;
            if (!slv_act)      samp_cnt_q <= '0;
            else if (s_end)    samp_cnt_q <= '0;
            else if (s_sample) samp_cnt_q <= samp_cnt_q + 1'b1;
        end
    end

    // Completion and fault flags with the status-then-data clear sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            seen_q  <= 1'b0;
        end else begin
            if (clr_flags) begin
                done_q  <= 1'b0;
                fault_q <= 1'b0;
            end
            if (set_done) done_q <= 1'b1;
            if (fault_ev) begin
                done_q  <= 1'b1;
                fault_q <= 1'b1;
            end
            if (rd_stat && (done_q || fault_q)) seen_q <= 1'b1;
            else if (rd_data)                   seen_q <= 1'b0;
        end
    end

    // Readable data register, loaded when a byte completes.
    always_ff @(posedge clk) begin
        if (!rst_n)        data_q <= '0;
        else if (set_done) data_q <= rx_now;
    end

    // Register read mux.
    always_comb begin
        bus_rdata = '0;
        if (int'(bus_addr) == ADDR_CTL)       bus_rdata[CTL_W-1:0] = ctl_q;
        else if (int'(bus_addr) == ADDR_STAT) bus_rdata[1:0]       = {fault_q, done_q};
        else if (int'(bus_addr) == ADDR_DATA) bus_rdata            = data_q;
    end

    assign sck_o  = (ctl_q.master && busy_q) ? sck_q : ctl_q.cpol;
    assign mosi_o = out_bit;
    assign miso_o = out_bit;

endmodule

// File: rtl/spi_xfer_core_chk.sv
// Checker: temporal properties of the serial engine, bound into the top.
// Assumes it sees the top's internal state through the bind connections.
module spi_xfer_core_chk (
    input logic clk,
    input logic rst_n,
    input logic master,
    input logic cpol,
    input logic busy,
    input logic tick,
    input logic fault_ev,
    input logic wr_ctl,
    input logic clr_flags,
    input logic set_done,
    input logic done,
    input logic fault,
    input logic sck_q,
    input logic sck_o
);

    // R3
    sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick && !fault_ev) |=> $stable(sck_q));

    // R2
    idle_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && master && $stable(cpol)) |-> (sck_q == cpol));

    // R7
    mode_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_ev |=> (!master && fault && done && !busy));

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flags && !set_done && !fault_ev) |=> (!done && !fault));

    // R8
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!master && !wr_ctl) |=> $stable(sck_o));

endmodule

bind spi_xfer_core spi_xfer_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .master(ctl_q.master), .cpol(ctl_q.cpol),
    .busy(busy_q), .tick(tick), .fault_ev(fault_ev), .wr_ctl(wr_ctl),
    .clr_flags(clr_flags), .set_done(set_done), .done(done_q),
    .fault(fault_q), .sck_q(sck_q), .sck_o(sck_o));

// File: tb/spi_xfer_core_test.sv
`timescale 1ns/1ps
module spi_xfer_core_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1, lb_en = 1'b1;
    logic       sck_o, mosi_o, miso_i, miso_o;
    int         checks = 0, errors = 0;
    bit         finished = 1'b0;

    always #2.5 clk = ~clk;

    assign miso_i = lb_en ? ~mosi_o : 1'b0;

    spi_xfer_core uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_i(sck_i), .sck_o(sck_o), .mosi_i(mosi_i), .mosi_o(mosi_o),
        .miso_i(miso_i), .miso_o(miso_o), .ss_n_i(ss_n_i));

    // {rate[2:0], cpol, cpha, 3'b0, tx[7:0], divisor[7:0]}
    localparam logic [23:0] VEC [8] = '{
        {3'b000, 1'b0, 1'b0, 3'b0, 8'hA5, 8'd4},
        {3'b001, 1'b1, 1'b0, 3'b0, 8'h3C, 8'd16},
        {3'b010, 1'b0, 1'b1, 3'b0, 8'h81, 8'd64},
        {3'b011, 1'b1, 1'b1, 3'b0, 8'h5A, 8'd128},
        {3'b100, 1'b0, 1'b0, 3'b0, 8'hF0, 8'd2},
        {3'b101, 1'b1, 1'b1, 3'b0, 8'h0F, 8'd8},
        {3'b110, 1'b0, 1'b1, 3'b0, 8'h96, 8'd32},
        {3'b111, 1'b1, 1'b0, 3'b0, 8'hE7, 8'd64}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a; #1;
        v = bus_rdata;
    endtask

    task automatic clear_flags();
        bus_read(2'd1);
        bus_read(2'd2);
    endtask

    // Slave transfer driven by the bench acting as the remote master.
    task automatic slave_xfer(input logic [2:0] rate, input bit cpol, input bit cpha,
                              input logic [7:0] load, input logic [7:0] pat);
        logic [7:0] got, v;
        int         tog;
        logic       prev;
        got = 8'h00; tog = 0;
        sck_i = cpol;
        bus_write(2'd0, {2'b00, rate, cpha, cpol, 1'b0});
        bus_write(2'd2, load);
        @(negedge clk); ss_n_i = 1'b0;
        prev = sck_o;
        for (int i = 7; i >= 0; i--) begin
            if (!cpha) begin
                mosi_i = pat[i];
                repeat (8) @(posedge clk);
                #1; got[i] = miso_o;
                sck_i = ~cpol;
                repeat (8) @(posedge clk);
                #1; sck_i = cpol;
                repeat (8) @(posedge clk);
            end else begin
                #1; sck_i = ~cpol;
                repeat (8) @(posedge clk);
                #1; mosi_i = pat[i]; got[i] = miso_o;
                repeat (8) @(posedge clk);
                #1; sck_i = cpol;
                repeat (8) @(posedge clk);
            end
            #1; if (sck_o != prev) tog++;
            prev = sck_o;
        end
        repeat (8) @(posedge clk);
        #1;
        peek(2'd1, v);
        chk(v == 8'h01, "R8 slave completion flag", v, 8'h01);
        peek(2'd2, v);
        chk(v == pat, "R8 slave captured byte", v, pat);
        chk(got == load, "R8 slave shifted-out byte on miso", got, load);
        chk(tog == 0 && sck_o == cpol, "R8 no serial clock from slave", tog, 0);
        clear_flags();
        @(negedge clk); ss_n_i = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    initial begin
        logic [7:0] v;
        logic [2:0] rate;
        bit         cpol, cpha;
        logic [7:0] tx;
        int         div, n, tog;
        logic       prev;

        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        peek(2'd0, v); chk(v == 8'h00, "R1 control after reset", v, 0);
        peek(2'd1, v); chk(v == 8'h00, "R1 status after reset", v, 0);
        peek(2'd2, v); chk(v == 8'h00, "R1 data after reset", v, 0);
        chk(sck_o == 1'b0, "R1 sck low after reset", sck_o, 0);

        // R2 idle level follows polarity immediately
        bus_write(2'd0, 8'b0000_0010);
        chk(sck_o == 1'b1, "R2 idle high after polarity write", sck_o, 1);
        bus_write(2'd0, 8'b0000_0000);
        chk(sck_o == 1'b0, "R2 idle low after polarity write", sck_o, 0);

        // R3 R4 R5 R6: rate table walked with looped-back transfers
        for (int k = 0; k < 8; k++) begin
            rate = VEC[k][23:21]; cpol = VEC[k][20]; cpha = VEC[k][19];
            tx = VEC[k][15:8]; div = int'(VEC[k][7:0]);
            bus_write(2'd0, {2'b00, rate, cpha, cpol, 1'b1});
            chk(sck_o == cpol, "R2 idle level before transfer", sck_o, cpol);
            bus_write(2'd2, tx);
            if (!cpha) chk(mosi_o == tx[7], "R4 first bit before first edge", mosi_o, tx[7]);
            n = 0; tog = 0; prev = sck_o;
            do begin
                @(posedge clk); #1;
                n++;
                if (sck_o != prev) tog++;
                prev = sck_o;
                peek(2'd1, v);
            end while (v[0] == 1'b0 && n < 4000);
            chk(n == 8 * div, "R5 transfer length in cycles", n, 8 * div);
            chk(tog == 16, "R3 sck transitions per transfer", tog, 16);
            chk(sck_o == cpol, "R2 idle level after transfer", sck_o, cpol);
            peek(2'd2, v);
            chk(v == ~tx, "R3 R4 captured byte msb first", v, ~tx);
            bus_read(2'd1);
            bus_read(2'd2);
            peek(2'd1, v);
            chk(v == 8'h00, "R6 flag cleared by status then data", v, 0);
        end

        // R7 mode fault mid-transfer
        bus_write(2'd0, {2'b00, 3'b011, 1'b0, 1'b0, 1'b1});
        bus_write(2'd2, 8'h33);
        repeat (200) @(posedge clk);
        @(negedge clk); ss_n_i = 1'b0;
        repeat (6) @(posedge clk);
        #1;
        peek(2'd0, v); chk(v[0] == 1'b0, "R7 master bit cleared by fault", v[0], 0);
        peek(2'd1, v); chk(v == 8'h03, "R7 fault and completion flags", v, 3);
        chk(sck_o == 1'b0, "R7 sck back to idle on fault", sck_o, 0);
        @(negedge clk); ss_n_i = 1'b1;
        repeat (4) @(posedge clk);
        clear_flags();
        peek(2'd1, v); chk(v == 8'h00, "R7 fault flag cleared", v, 0);
        bus_write(2'd2, 8'h44);
        tog = 0; prev = sck_o;
        for (int i = 0; i < 600; i++) begin
            @(posedge clk); #1;
            if (sck_o != prev) tog++;
            prev = sck_o;
        end
        chk(tog == 0, "R7 no transfer until master rewritten", tog, 0);
        peek(2'd1, v); chk(v == 8'h00, "R7 no completion while master off", v, 0);
        bus_write(2'd0, {2'b00, 3'b100, 1'b0, 1'b0, 1'b1});
        bus_write(2'd2, 8'h69);
        repeat (40) @(posedge clk);
        #1;
        peek(2'd1, v); chk(v == 8'h01, "R7 master resumes after rewrite", v, 1);
        peek(2'd2, v); chk(v == 8'h96, "R7 resumed transfer data", v, 8'h96);

        // R6 data read alone leaves the flag set
        bus_read(2'd2);
        peek(2'd1, v); chk(v == 8'h01, "R6 data read alone keeps flag", v, 1);
        clear_flags();
        peek(2'd1, v); chk(v == 8'h00, "R6 flag cleared after sequence", v, 0);

        // R8 slave mode under two rate codes and both phases
        lb_en = 1'b0;
        slave_xfer(3'b011, 1'b0, 1'b0, 8'hC5, 8'h9B);
        slave_xfer(3'b100, 1'b1, 1'b1, 8'h2E, 8'h71);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule